// File: doc/BRIEF.md
# Timed DAC Write Controller

This block sits on the host side of a serial-input digital-to-analog converter. It accepts 16-bit sample words over a valid/ready handshake. Each word goes out on three lines: an active-low select, a serial clock and a serial data line. A separate active-low clear line can be pulsed on request. Every edge on these lines is placed by a cycle counter that runs from the fast system clock. As a result, the converter's minimum pulse widths, setup times and hold times are met at any system clock period the parameters allow.

All timing limits are parameters in picoseconds. The block turns each one into a cycle count, rounding up. After reset the block holds off all traffic until a power-up wait has expired. A per-word flag selects signed input. When it is set, the two's-complement sample is turned into the offset-binary code that a bipolar converter expects, by inverting its top bit.

Top module: `dac_serial_writer`

## Requirements
- R1: While reset is asserted, sel_n is 1, ser_clk is 0, ser_dat is 0, dac_clr_n is 1 and s_ready is 0.
- R2: After reset is released, s_ready stays 0 and sel_n stays 1 for at least the power-up wait (20 µs by default).
- R3: A word is taken on a clock edge where s_valid and s_ready are both 1. sel_n falls on that same edge. s_ready stays 0 until the frame and the gap after it are complete, and every word taken is sent exactly once, in order.
- R4: A frame carries exactly 16 bits, most significant first. Each bit is taken by the converter on a rising ser_clk edge. While sel_n is 1, ser_clk is 0 and ser_dat keeps its last value.
- R5: Each high phase of ser_clk lasts at least 20 ns and each low phase at least 20 ns. Successive rising edges are at least 40 ns apart.
- R6: ser_dat is stable for at least 15 ns before each rising ser_clk edge and does not change while ser_clk is high.
- R7: The first rising ser_clk edge comes at least 15 ns after sel_n falls. sel_n rises no sooner than 20 ns after the last rising edge.
- R8: sel_n falls no sooner than 35 ns after any earlier rising ser_clk edge. A rising edge comes no sooner than 15 ns after sel_n rises.
- R9: When s_signed is 1 at acceptance, the word sent is s_data with bit 15 inverted (0xFFFF goes out as 0x7FFF, 0x8000 as 0x0000, 0x0000 as 0x8000). When s_signed is 0, s_data is sent unchanged.
- R10: clr_req sampled at 1 drives dac_clr_n to 0 on that edge. The line stays low for ceil(20 ns / clock period) cycles, which is 4 at 5 ns. A new request during the pulse restarts the count. Requests are honoured during the power-up wait as well.
- R11: A clear request at any time does not change the word sent or its timing. This includes the edge that accepts a word and any point inside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample word offered |
| s_ready | output | 1 | Block can take a word this cycle |
| s_data | input | WORD_W | Sample word |
| s_signed | input | 1 | Treat s_data as two's complement and send offset binary |
| clr_req | input | 1 | Request a clear pulse |
| sel_n | output | 1 | Active-low converter select |
| ser_clk | output | 1 | Serial clock to the converter |
| ser_dat | output | 1 | Serial data, MSB first |
| dac_clr_n | output | 1 | Active-low clear pulse to the converter |

## Verification
The clear pulse generator and the frame sequencer can act on the same clock edge. A clear request can land exactly on the edge that accepts a word, or anywhere inside a frame. A directed item raises clr_req in the cycle where s_valid and s_ready are both high, and random clear requests fall across roughly 250 random frames. The clear line is judged every cycle against a countdown model. Meanwhile each frame is decoded from the serial pins and compared with the expected code, and all its edge spacings are checked, so any disturbance from the clear path shows up as a wrong word or a timing shortfall.

// File: rtl/dac_serial_writer.sv
`timescale 1ns/1ps
module dac_serial_writer #(
  parameter int WORD_W        = 16,
  parameter int SYS_CLK_PS    = 5000,
  parameter int T_HIGH_PS     = 20000,
  parameter int T_LOW_PS      = 20000,
  parameter int T_CYCLE_PS    = 40000,
  parameter int T_DSU_PS      = 15000,
  parameter int T_SEL_SU_PS   = 15000,
  parameter int T_DESEL_SU_PS = 15000,
  parameter int T_RESEL_PS    = 35000,
  parameter int T_SEL_HOLD_PS = 20000,
  parameter int T_CLR_PS      = 20000,
  parameter int T_POWERUP_PS  = 20000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_signed,
  input  logic              clr_req,
  output logic              sel_n,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              dac_clr_n
);

  function automatic int cyc_of(input int t_ps);
    return (t_ps + SYS_CLK_PS - 1) / SYS_CLK_PS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HI_C   = imax(1, cyc_of(T_HIGH_PS));
  localparam int LO_C   = imax(imax(1, cyc_of(T_LOW_PS)),
                               imax(cyc_of(T_DSU_PS), cyc_of(T_CYCLE_PS) - HI_C));
  localparam int LEAD_C = imax(1, imax(cyc_of(T_SEL_SU_PS), cyc_of(T_DSU_PS)));
  localparam int TAIL_C = imax(1, cyc_of(T_SEL_HOLD_PS) - HI_C);
  localparam int GAP_C  = imax(imax(1, cyc_of(T_RESEL_PS) - HI_C - TAIL_C),
                               imax(cyc_of(T_DESEL_SU_PS) - LEAD_C,
                                    imax(LO_C - TAIL_C - LEAD_C,
                                         cyc_of(T_CYCLE_PS) - HI_C - TAIL_C - LEAD_C)));
  localparam int CLR_C  = imax(1, cyc_of(T_CLR_PS));
  localparam int PWR_C  = imax(1, cyc_of(T_POWERUP_PS));
  localparam int TMAX   = imax(PWR_C, imax(imax(HI_C, LO_C), imax(imax(LEAD_C, TAIL_C), GAP_C)));
  localparam int TW     = $clog2(TMAX + 1);
  localparam int BW     = $clog2(WORD_W);
  localparam int CW     = $clog2(CLR_C + 1);

  if (WORD_W < 2 || SYS_CLK_PS < 1 || T_POWERUP_PS < 0) begin : g_bad_cfg
    $error("dac_serial_writer: word width or clock period out of range");
  end
  if (HI_C * SYS_CLK_PS < T_HIGH_PS || (HI_C + LO_C) * SYS_CLK_PS < T_CYCLE_PS ||
      LEAD_C * SYS_CLK_PS < T_SEL_SU_PS || (HI_C + TAIL_C) * SYS_CLK_PS < T_SEL_HOLD_PS) begin : g_bad_timing
    $error("dac_serial_writer: derived cycle counts miss a timing minimum");
  end

  typedef enum logic [2:0] {ST_PWR, ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_TAIL, ST_GAP} st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic [BW-1:0]     bcnt;
  logic [WORD_W-1:0] sreg;
  logic [CW-1:0]     ccnt;
  logic [WORD_W-1:0] conv;

  assign conv    = {s_data[WORD_W-1] ^ s_signed, s_data[WORD_W-2:0]};
  assign s_ready = (st == ST_IDLE);
  assign ser_dat = sreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_PWR;
      tmr     <= TW'(PWR_C - 1);
      bcnt    <= '0;
      sreg    <= '0;
      sel_n   <= 1'b1;
      ser_clk <= 1'b0;
    end else if (st != ST_IDLE && tmr != '0) begin
      tmr <= tmr - 1'b1;
    end else begin
      unique case (st)
        ST_PWR: st <= ST_IDLE;
        ST_IDLE:
          if (s_valid) begin
            sreg  <= conv;
            sel_n <= 1'b0;
            bcnt  <= BW'(WORD_W - 1);
            tmr   <= TW'(LEAD_C - 1);
            st    <= ST_LEAD;
          end
        ST_LEAD, ST_LOW: begin
          ser_clk <= 1'b1;
          tmr     <= TW'(HI_C - 1);
          st      <= ST_HIGH;
        end
        ST_HIGH: begin
          ser_clk <= 1'b0;
          if (bcnt == '0) begin
            tmr <= TW'(TAIL_C - 1);
            st  <= ST_TAIL;
          end else begin
            bcnt <= bcnt - 1'b1;
            sreg <= {sreg[WORD_W-2:0], 1'b0};
            tmr  <= TW'(LO_C - 1);
            st   <= ST_LOW;
          end
        end
        ST_TAIL: begin
          sel_n <= 1'b1;
          tmr   <= TW'(GAP_C - 1);
          st    <= ST_GAP;
        end
        ST_GAP: st <= ST_IDLE;
        default: st <= ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt      <= '0;
      dac_clr_n <= 1'b1;
    end else if (clr_req) begin
      ccnt      <= CW'(CLR_C - 1);
      dac_clr_n <= 1'b0;
    end else if (ccnt != '0) begin
      ccnt <= ccnt - 1'b1;
    end else begin
      dac_clr_n <= 1'b1;
    end
  end

endmodule

// File: rtl/dac_serial_writer_chk.sv
`timescale 1ns/1ps
module dac_serial_writer_chk #(
  parameter int SYS_CLK_PS   = 5000,
  parameter int T_CLR_PS     = 20000,
  parameter int T_POWERUP_PS = 20000000
) (
  input logic clk,
  input logic rst_n,
  input logic s_ready,
  input logic clr_req,
  input logic sel_n,
  input logic ser_clk,
  input logic ser_dat,
  input logic dac_clr_n
);

  localparam int CLR_RAW = (T_CLR_PS + SYS_CLK_PS - 1) / SYS_CLK_PS;
  localparam int PWR_RAW = (T_POWERUP_PS + SYS_CLK_PS - 1) / SYS_CLK_PS;
  localparam int CLR_C   = (CLR_RAW > 1) ? CLR_RAW : 1;
  localparam int PWR_C   = (PWR_RAW > 1) ? PWR_RAW : 1;
  localparam int UW      = $clog2(PWR_C + 2);
  localparam int LW      = $clog2(CLR_C + 2);

  logic [UW-1:0] up_cnt;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != UW'(PWR_C)) up_cnt <= up_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (dac_clr_n) low_cnt <= '0;
    else if (low_cnt != LW'(CLR_C)) low_cnt <= low_cnt + 1'b1;
  end

  assert_ready_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> up_cnt >= UW'(PWR_C));
  assert_select_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> up_cnt >= UW'(PWR_C));
  assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> !s_ready);
  assert_clock_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !ser_clk);
  assert_data_steady_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_dat));
  assert_select_on_low_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> !ser_clk);
  assert_clear_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !dac_clr_n);
  assert_clear_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_clr_n) |-> low_cnt >= LW'(CLR_C));

endmodule

bind dac_serial_writer dac_serial_writer_chk #(
  .SYS_CLK_PS  (SYS_CLK_PS),
  .T_CLR_PS    (T_CLR_PS),
  .T_POWERUP_PS(T_POWERUP_PS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_ready  (s_ready),
  .clr_req  (clr_req),
  .sel_n    (sel_n),
  .ser_clk  (ser_clk),
  .ser_dat  (ser_dat),
  .dac_clr_n(dac_clr_n)
);

// File: tb/dac_serial_writer_test.sv
`timescale 1ns/1ps
module dac_serial_writer_test;
  localparam int PER_NS  = 5;
  localparam int CLR_CYC = (20 + PER_NS - 1) / PER_NS;
  localparam int N_DIR   = 8;
  localparam int N_ITEMS = 260;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        s_valid = 1'b0, s_signed = 1'b0, clr_req = 1'b0;
  logic [15:0] s_data = '0;
  logic        s_ready, sel_n, ser_clk, ser_dat, dac_clr_n;

  always #2.5 clk = ~clk;

  dac_serial_writer uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_signed(s_signed), .clr_req(clr_req),
    .sel_n(sel_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .dac_clr_n(dac_clr_n)
  );

  int n_chk = 0, n_bad = 0;
  bit run = 0;
  logic [15:0] dir_d [N_DIR];
  bit          dir_s [N_DIR];
  bit          dir_c [N_DIR];
  logic [15:0] q_word [$];
  bit          q_sgn  [$];

  function automatic logic [15:0] code_of(input logic [15:0] d, input bit sg);
    return sg ? {~d[15], d[14:0]} : d;
  endfunction

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_min(input string req, input string what, input longint act, input longint lim);
    n_chk++;
    if (act < lim) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lim);
    end
  endtask

  task automatic wrap_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h1d5a7c3));
    dir_d[0] = 16'h0000; dir_s[0] = 0; dir_c[0] = 0;
    dir_d[1] = 16'hFFFF; dir_s[1] = 0; dir_c[1] = 0;
    dir_d[2] = 16'h8000; dir_s[2] = 0; dir_c[2] = 0;
    dir_d[3] = 16'h1234; dir_s[3] = 0; dir_c[3] = 1;
    dir_d[4] = 16'hFFFF; dir_s[4] = 1; dir_c[4] = 0;
    dir_d[5] = 16'h8000; dir_s[5] = 1; dir_c[5] = 0;
    dir_d[6] = 16'h0000; dir_s[6] = 1; dir_c[6] = 1;
    dir_d[7] = 16'h7FFF; dir_s[7] = 1; dir_c[7] = 0;
    repeat (3) @(negedge clk);
    chk_eq("R1", "sel_n in reset", sel_n, 1);
    chk_eq("R1", "ser_clk in reset", ser_clk, 0);
    chk_eq("R1", "ser_dat in reset", ser_dat, 0);
    chk_eq("R1", "dac_clr_n in reset", dac_clr_n, 1);
    chk_eq("R1", "s_ready in reset", s_ready, 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1 run = 1;
  end

  int cyc = 0, idx = 0, gap = 0, quiet = 0, clr_left = 0, nbits = 0;
  int t_rise = 0, t_fall = 0, t_sel = 0, t_desel = 0, t_dat = 0;
  bit seen_rise = 0, seen_fall = 0, seen_desel = 0, cur_clr = 0;
  bit prev_sel = 1, prev_clk = 0, prev_dat = 0, rdy_prev = 0;
  logic [15:0] got = '0;

  always @(negedge clk) if (run) begin
    bit acc, rise, fall, sg;
    logic [15:0] w;
    string tag;
    cyc++;

    acc = s_valid && rdy_prev;
    if (acc) begin
      q_word.push_back(code_of(s_data, s_signed));
      q_sgn.push_back(s_signed);
      chk_eq("R3", "select falls on acceptance edge", {prev_sel, sel_n}, 2'b10);
    end
    if (s_ready) begin
      chk_min("R2", "ns before ready", cyc * PER_NS, 20000);
      chk_eq("R3", "ready while selected", sel_n, 1);
    end

    if (sel_n) chk_eq("R4", "clock idle while deselected", ser_clk, 0);
    if (sel_n && prev_sel) chk_eq("R4", "data held between frames", ser_dat, prev_dat);

    if (prev_sel && !sel_n) begin
      chk_eq("R4", "clock low at select", ser_clk, 0);
      chk_min("R2", "ns to first select", cyc * PER_NS, 20000);
      if (seen_rise) chk_min("R8", "rise to select ns", (cyc - t_rise) * PER_NS, 35);
      t_sel = cyc;
      nbits = 0;
    end

    if (ser_dat != prev_dat) begin
      if (prev_clk) chk_eq("R6", "data change during high phase", ser_clk, 0);
      t_dat = cyc;
    end

    rise = !prev_clk && ser_clk;
    fall = prev_clk && !ser_clk;
    if (rise) begin
      chk_eq("R4", "rise only while selected", sel_n, 0);
      chk_min("R6", "data setup ns", (cyc - t_dat) * PER_NS, 15);
      if (nbits == 0) begin
        chk_min("R7", "select to first rise ns", (cyc - t_sel) * PER_NS, 15);
        if (seen_desel) chk_min("R8", "deselect to rise ns", (cyc - t_desel) * PER_NS, 15);
      end
      if (seen_fall) chk_min("R5", "low phase ns", (cyc - t_fall) * PER_NS, 20);
      if (seen_rise) chk_min("R5", "rise to rise ns", (cyc - t_rise) * PER_NS, 40);
      got = {got[14:0], ser_dat};
      nbits++;
      t_rise = cyc;
      seen_rise = 1;
    end
    if (fall) begin
      chk_min("R5", "high phase ns", (cyc - t_rise) * PER_NS, 20);
      t_fall = cyc;
      seen_fall = 1;
    end

    if (!prev_sel && sel_n) begin
      chk_eq("R4", "bits per frame", nbits, 16);
      chk_min("R7", "last rise to deselect ns", (cyc - t_rise) * PER_NS, 20);
      if (q_word.size() == 0) chk_eq("R3", "frame without accepted word", 1, 0);
      else begin
        w = q_word.pop_front();
        sg = q_sgn.pop_front();
        if (sg) tag = "R9"; else tag = "R4";
        chk_eq(tag, "word sent", got, w);
      end
      t_desel = cyc;
      seen_desel = 1;
    end

    if (clr_req) clr_left = CLR_CYC;
    if (!sel_n) tag = "R11"; else tag = "R10";
    chk_eq(tag, "clear line", dac_clr_n, (clr_left > 0) ? 0 : 1);
    if (clr_left > 0) clr_left--;

    prev_sel = sel_n;
    prev_clk = ser_clk;
    prev_dat = ser_dat;
    rdy_prev = s_ready;

    if (acc) s_valid = 1'b0;
    if (!s_valid && idx < N_ITEMS) begin
      if (gap > 0) gap--;
      else begin
        if (idx < N_DIR) begin
          s_data = dir_d[idx]; s_signed = dir_s[idx]; cur_clr = dir_c[idx];
        end else begin
          s_data = 16'($urandom); s_signed = 1'($urandom_range(0, 1)); cur_clr = 0;
        end
        s_valid = 1'b1;
        idx++;
        gap = $urandom_range(0, 3);
      end
    end
    clr_req = 1'b0;
    if (cur_clr && s_valid && s_ready) begin
      clr_req = 1'b1;
      cur_clr = 0;
    end else if (cyc == 100 || cyc == 200 || cyc == 202) clr_req = 1'b1;
    else if (idx >= N_DIR && $urandom_range(0, 59) == 0) clr_req = 1'b1;

    if (idx == N_ITEMS && !s_valid && sel_n && q_word.size() == 0) quiet++;
    else quiet = 0;
    if (quiet > 20) begin
      chk_eq("R3", "accepted words all sent", q_word.size(), 0);
      wrap_up();
    end
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog: actual=%0d cycles expected<150000", cyc);
      wrap_up();
    end
  end
endmodule